// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Band Insertion

This block drives the two switches of a half-bridge power stage from one free-running period counter. The counter runs from zero up to a programmed period value and then wraps. The primary output is meant to be on while the count is below a programmed duty value. The complementary output is meant to be on for the rest of the period. Both outputs are active-high.

To stop the two switches from ever conducting together, each output's off-to-on edge is held back by a programmable dead-band count of 0 to 127 clocks. The on-to-off edge is never delayed. If the dead-band count is at least as long as the window in which an output would be on, that output stays off for the whole window.

The period, duty and dead-band inputs are double-buffered. The block copies them into its working set only at a period wrap, or while it is disabled. A change therefore never lands in the middle of a cycle. When the enable is low or reset is high, both outputs are held off.

Top module: `pwm_db_top`

## Requirements
- R1: While `rst` is high, both outputs are low. After `rst` falls with `en` low, both outputs stay low.
- R2: While `en` is low, both outputs are low in that same cycle. The counter is then held at zero and the working set follows the inputs.
- R3: With period value P, the counter steps 0,1,…,P and then returns to 0, so one period lasts P+1 clocks. The first enabled cycle is count 0.
- R4: With dead-band 0 and 1 ≤ D ≤ P, `pwm_hi` is high exactly at the counts k < D, where D is the duty value.
- R5: With dead-band 0 and 1 ≤ D ≤ P, `pwm_lo` is high exactly at the counts k ≥ D, so it is the exact complement of `pwm_hi`.
- R6: With dead-band d, `pwm_hi` is high exactly at the counts d ≤ k < D. Its rising edge comes d clocks late and its falling edge is not moved.
- R7: With dead-band d, `pwm_lo` is high exactly at the counts k ≥ D+d. Its falling edge at the wrap is not moved.
- R8: An output whose dead-band count is at least its window length (D for `pwm_hi`, P+1−D for `pwm_lo`) stays low for the entire period.
- R9: `pwm_hi` and `pwm_lo` are never high in the same cycle.
- R10: Period, duty and dead-band inputs changed in the middle of a period leave that period unchanged. They take effect from count 0 of the next period.
- R11: Duty 0 keeps `pwm_hi` low throughout, and `pwm_lo` stays high continuously once its dead-band has elapsed. A duty above P keeps `pwm_lo` low, and `pwm_hi` stays high continuously once its dead-band has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces both outputs off and restarts the counter |
| period_in | input | 8 | Period value P (period is P+1 clocks), buffered |
| duty_in | input | 8 | Duty value D, buffered |
| dband_in | input | 7 | Dead-band count d in clocks, buffered |
| pwm_hi | output | 1 | Primary PWM output, active-high |
| pwm_lo | output | 1 | Complementary PWM output, active-high |

## Verification
The period wrap and the reload of the buffered settings happen in the same cycle. In that cycle the primary output's dead-band counter must also pick up the new dead-band value instead of the stale one. The bench provokes this by changing all three inputs in the middle of a period to a setting whose new dead-band covers the whole primary window. It then checks that the old period runs to the end unchanged and that the primary output stays off in the following periods. A sweep over every period from 1 to 7, every duty from 1 to P and every dead-band from 0 to 8 compares both outputs in every count of two consecutive periods against the closed-form windows.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;

    localparam int CNT_W  = 8;
    localparam int DB_W   = 7;
    localparam int NUM_CH = 2;
    localparam int CH_HI  = 0;
    localparam int CH_LO  = 1;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [DB_W-1:0]  db_t;

    typedef struct packed {
        cnt_t per;
        cnt_t duty;
        db_t  db;
    } pwm_cfg_t;

    function automatic logic in_primary(input cnt_t cnt, input cnt_t duty);
        return cnt < duty;
    endfunction

endpackage

// File: rtl/pwm_db_shadow.sv
module pwm_db_shadow
    import pwm_db_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     wrap,
    input  pwm_cfg_t cfg_in,
    output pwm_cfg_t cfg_q,
    output pwm_cfg_t cfg_nxt
);

    logic load;

    // The working set follows the inputs while idle, else only at the wrap.
    assign load    = !en || wrap;
    assign cfg_nxt = load ? cfg_in : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_nxt;
        end
    end

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (en && !wrap) |=> $stable(cfg_q));

endmodule

// File: rtl/pwm_db_timebase.sv
module pwm_db_timebase
    import pwm_db_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  pwm_cfg_t          cfg_q,
    output logic              wrap,
    output logic [NUM_CH-1:0] win
);

    cnt_t cnt;
    logic prim;

    assign wrap = (cnt == cfg_q.per);
    assign prim = in_primary(cnt, cfg_q.duty);
    assign win[CH_HI] = prim;
    assign win[CH_LO] = !prim;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + cnt_t'(1);
        end
    end

    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt <= cfg_q.per));

endmodule

// File: rtl/pwm_db_deadband.sv
module pwm_db_deadband
    import pwm_db_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic win,
    input  db_t  db_load,
    output logic drive
);

    db_t dc;

    // Reloaded whenever the ideal window is closed; counts down inside it.
    always_ff @(posedge clk) begin
        if (rst) begin
            dc <= '0;
        end else if (!en || !win) begin
            dc <= db_load;
        end else if (dc != '0) begin
            dc <= dc - db_t'(1);
        end
    end

    assign drive = en && !rst && win && (dc == '0);

    assert_start_delay_R6: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(rst) && win && !$past(win) && ($past(db_load) != '0))
        |-> !drive);

endmodule

// File: rtl/pwm_db_top.sv
module pwm_db_top
    import pwm_db_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [DB_W-1:0]  dband_in,
    output logic             pwm_hi,
    output logic             pwm_lo
);

    pwm_cfg_t          cfg_in;
    pwm_cfg_t          cfg_q;
    pwm_cfg_t          cfg_nxt;
    logic              wrap;
    logic [NUM_CH-1:0] win;
    logic [NUM_CH-1:0] drv;

    assign cfg_in = '{per: period_in, duty: duty_in, db: dband_in};

    pwm_db_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .wrap    (wrap),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q),
        .cfg_nxt (cfg_nxt)
    );

    pwm_db_timebase u_timebase (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .cfg_q (cfg_q),
        .wrap  (wrap),
        .win   (win)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_db_deadband u_db (
            .clk     (clk),
            .rst     (rst),
            .en      (en),
            .win     (win[g]),
            .db_load (cfg_nxt.db),
            .drive   (drv[g])
        );
    end

    assign pwm_hi = drv[CH_HI];
    assign pwm_lo = drv[CH_LO];

    assert_never_overlap_R9: assert property (@(posedge clk) disable iff (rst)
        !(pwm_hi && pwm_lo));

endmodule

// File: tb/pwm_db_top_tb.sv
module pwm_db_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic [7:0] period_in;
    logic [7:0] duty_in;
    logic [6:0] dband_in;
    logic       pwm_hi;
    logic       pwm_lo;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pwm_db_top dut_i (
        .clk(clk), .rst(rst), .en(en),
        .period_in(period_in), .duty_in(duty_in), .dband_in(dband_in),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    // Closed-form windows for count k of a period (P, D, d)
    function automatic logic e_hi(int k, int dv, int d);
        return (k < dv) && (k >= d);
    endfunction
    function automatic logic e_lo(int k, int dv, int d);
        return k >= dv + d;
    endfunction

    // Idle one cycle with the new setting so it loads, then enable.
    task automatic start_cfg(input int p, input int dv, input int d);
        @(negedge clk);
        en = 1'b0; period_in = 8'(p); duty_in = 8'(dv); dband_in = 7'(d);
        #1;
        chk("R2", "hi idle", pwm_hi, 1'b0);
        chk("R2", "lo idle", pwm_lo, 1'b0);
        @(negedge clk);
        en = 1'b1;
    endtask

    // Check one period; assumes we are in the negedge half of count 0.
    task automatic run_period(input string rq, input int p, input int dv, input int d);
        for (int k = 0; k <= p; k++) begin
            #1;
            chk(rq, "hi", pwm_hi, e_hi(k, dv, d));
            chk(rq, "lo", pwm_lo, e_lo(k, dv, d));
            chk("R9", "overlap", pwm_hi & pwm_lo, 1'b0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 1'b1; period_in = 8'd5; duty_in = 8'd2; dband_in = 7'd0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "hi in reset", pwm_hi, 1'b0);
        chk("R1", "lo in reset", pwm_lo, 1'b0);
        @(negedge clk);
        en = 1'b0; rst = 1'b0;
        #1;
        chk("R1", "hi after reset", pwm_hi, 1'b0);
        chk("R1", "lo after reset", pwm_lo, 1'b0);

        // R3 R4 R5 (d=0) and R6 R7 R8 (d>0): sweep, two periods each
        for (int p = 1; p <= 7; p++)
            for (int dv = 1; dv <= p; dv++)
                for (int d = 0; d <= 8; d++) begin
                    start_cfg(p, dv, d);
                    run_period(d == 0 ? "R4/R5" : "R6/R7/R8", p, dv, d);
                    run_period("R3", p, dv, d);
                end

        // R8: long dead-band, complement never reached
        start_cfg(200, 150, 127);
        run_period("R8", 200, 150, 127);
        run_period("R8", 200, 150, 127);

        // R11: duty 0
        start_cfg(4, 0, 2);
        run_period("R11", 4, 0, 2);
        run_period("R11", 4, 0, 0);
        // R11: duty above period
        start_cfg(4, 6, 1);
        run_period("R11", 4, 6, 1);
        run_period("R11", 4, 6, 0);

        // R10: mid-period change; new d covers the primary window at the wrap
        start_cfg(5, 2, 0);
        for (int k = 0; k <= 5; k++) begin
            #1;
            chk("R10", "hi old", pwm_hi, e_hi(k, 2, 0));
            chk("R10", "lo old", pwm_lo, e_lo(k, 2, 0));
            @(negedge clk);
            if (k == 2) begin
                period_in = 8'd3; duty_in = 8'd1; dband_in = 7'd1;
            end
        end
        run_period("R10", 3, 1, 1);
        run_period("R10", 3, 1, 1);

        // R2: drop enable mid-period, outputs off in the same cycle
        start_cfg(6, 3, 0);
        @(negedge clk);
        en = 1'b0;
        #1;
        chk("R2", "hi disabled", pwm_hi, 1'b0);
        chk("R2", "lo disabled", pwm_lo, 1'b0);
        @(negedge clk);
        en = 1'b1;
        run_period("R3", 6, 3, 0);

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        #1;
        chk("R1", "hi reset mid", pwm_hi, 1'b0);
        chk("R1", "lo reset mid", pwm_lo, 1'b0);
        @(negedge clk);
        rst = 1'b0; en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        run_period("R1", 6, 3, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule